// File: doc/BRIEF.md
# Periodic Thermal Threshold Monitor

This block runs a two-source temperature converter on its own. After software sets thresholds, sampling periods and debounce counts, it sets the run bit. An idle counter then waits one period. The block next requests a conversion on source 0 and then on source 1 over a request/done handshake. It stores each 12-bit code and compares it with three thresholds for that source: warning, low and shutdown. Codes rise with temperature, so "at or above" a threshold means hotter.

Warning and shutdown conditions are debounced. Each has a count of consecutive qualifying samples that must be reached before it takes effect. A reached shutdown is latched until reset. It drives a pin-style output, a reset-request output, or neither, as chosen per source, with a selectable polarity. While any enabled source last read at or above its warning threshold, the idle wait uses a second, separately programmed period. Pending bits collect the events, and one interrupt line ORs the pending bits that are enabled.

Registers are reached through single-cycle writes and combinational reads on a 4-bit word address. The map is:

- 0 is control: bit0 run, bits 1..2 source enables, bit3 polarity, bits 4..5 low-compare enables.
- 1 is interrupt enable.
- 2 is pending.
- 3 is routing.
- 4 is the normal period.
- 5 is the hot period.
- 6 is debounce: bits 7:0 warning, bits 15:8 shutdown.
- 8 and 9 are the source results.
- 10 and 11 are the warning thresholds.
- 12 and 13 are the low thresholds.
- 14 and 15 are the shutdown thresholds.

Top module: `thermal_monitor`

## Requirements
- R1: After reset the following hold:
  - `adc_req_o` and `irq_o` are 0.
  - Both shutdown outputs are 1, which is the inactive level for the default active-low polarity.
  - Control, pending and result registers read 0.
- R2: With run set, `adc_req_o` stays low for exactly P cycles between rounds.
  - P is the normal period (address 4), or the hot period (address 5) if the previous round found an enabled source at or above its warning threshold.
  - A period of 0 behaves as 1.
- R3: Each round converts the sources in a fixed order.
  - Source 0 is converted first, then source 1.
  - `adc_req_o` stays high with `adc_ch_o` stable until `adc_done_i`.
  - Each code is stored in its result register (address 8+n).
  - The end of the round sets pending bit 6.
- R4: A source sample at or above its warning threshold increments a consecutive count; any other sample zeroes it. Pending bit n is set on every sample whose count is at or above the warning debounce value (0 acts as 1).
- R5: Pending bit 2+n is set on a sample below the source's low threshold when control bit 4+n is set.
- R6: Shutdown works like R4, using the shutdown threshold and debounce bits 15:8.
  - Reaching the count sets pending bit 4+n.
  - It also latches a shutdown for that source until reset.
- R7: Routing bit n enables the pin output and bit 2+n the reset request for source n.
  - A write that sets bit n forces bit 2+n to 0.
  - An output is active while a source routed to it is latched.
- R8: Control bit 3 = 1 makes both shutdown outputs active high; 0 makes them active low.
- R9: With control bit 1+n clear, source n still stores its code but raises no event and its counts restart from zero.
- R10: Writing 0 to a set pending bit clears it; writing 1 leaves it unchanged.
- R11: `irq_o` is the OR of the pending bits whose interrupt-enable bit (same position, address 1) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| adc_req_o | output | 1 | Conversion request, held until done |
| adc_ch_o | output | 1 | Source being converted |
| adc_done_i | input | 1 | Conversion complete, data valid |
| adc_data_i | input | 12 | Conversion code |
| irq_o | output | 1 | Interrupt |
| shut_gpio_o | output | 1 | Shutdown pin output |
| shut_rst_o | output | 1 | Shutdown reset request |

## Verification
The bench targets the debounce boundaries: a code exactly equal to a threshold, a run of samples broken one short of the count, and a debounce value of zero. A design that compares with strict greater-than, or that fails to restart the count on a cold sample, shows up as a pending bit in the wrong round. The bench measures the idle gap before every round against the period the previous round should have selected, which catches a period switch taken one round early or late. Routing writes that set both modes, a polarity flip while a shutdown is latched, and a disabled source fed hot codes complete the directed cases. Random codes drawn from four temperature bands run against a reference model.

// File: rtl/thermal_mon_pkg.sv
package thermal_mon_pkg;
  localparam int NUM_SRC = 2;
  localparam int ADDR_W  = 4;
  localparam int REG_W   = 32;
  localparam int PEND_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_IE     = 4'd1;
  localparam logic [ADDR_W-1:0] A_PEND   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PER    = 4'd4;
  localparam logic [ADDR_W-1:0] A_PER_HT = 4'd5;
  localparam logic [ADDR_W-1:0] A_DEB    = 4'd6;
  localparam logic [ADDR_W-1:0] A_DATA   = 4'd8;
  localparam logic [ADDR_W-1:0] A_WARN   = 4'd10;
  localparam logic [ADDR_W-1:0] A_LOW    = 4'd12;
  localparam logic [ADDR_W-1:0] A_SHUT   = 4'd14;

  // control bits
  localparam int C_RUN = 0;
  localparam int C_SRC = 1;
  localparam int C_POL = 3;
  localparam int C_LT  = 4;
  // routing bits
  localparam int R_PIN = 0;
  localparam int R_RST = 2;
  // pending bits
  localparam int P_HT  = 0;
  localparam int P_LT  = 2;
  localparam int P_SD  = 4;
  localparam int P_EOC = 6;

  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_e;
endpackage

// File: rtl/thermal_seq.sv
module thermal_seq
  import thermal_mon_pkg::*;
#(
  parameter int PERIOD_W = 32,
  parameter int N_SRC    = 2,
  parameter int CH_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [PERIOD_W-1:0] period_ht_i,
  input  logic                use_ht_i,
  input  logic                adc_done_i,
  output logic                adc_req_o,
  output logic [CH_W-1:0]     adc_ch_o,
  output logic                fire_o,
  output logic                round_end_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_SRC - 1);

  seq_state_e          state_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [CH_W-1:0]     ch_q;
  logic [PERIOD_W-1:0] per_sel, per_last;

  always_comb begin
    per_sel  = use_ht_i ? period_ht_i : period_i;
    per_last = (per_sel == '0) ? '0 : per_sel - 1'b1;
  end

  assign adc_req_o   = (state_q == SEQ_CONV);
  assign adc_ch_o    = ch_q;
  assign fire_o      = adc_req_o & adc_done_i;
  assign round_end_o = fire_o & (ch_q == LAST_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (!run_i) begin
            cnt_q <= '0;
          end else if (cnt_q >= per_last) begin
            state_q <= SEQ_CONV;
            cnt_q   <= '0;
            ch_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_CONV: begin
          if (adc_done_i) begin
            if (ch_q == LAST_CH) begin
              state_q <= SEQ_IDLE;
              ch_q    <= '0;
            end else begin
              ch_q <= ch_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_req_o && !adc_done_i) |=> (adc_req_o && $stable(adc_ch_o)));

  assert_first_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_req_o) |-> (adc_ch_o == '0));
endmodule

// File: rtl/thermal_chan.sv
module thermal_chan #(
  parameter int DATA_W = 12,
  parameter int DEB_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              src_en_i,
  input  logic              lt_en_i,
  input  logic [DATA_W-1:0] warn_i,
  input  logic [DATA_W-1:0] low_i,
  input  logic [DATA_W-1:0] shut_i,
  input  logic [DEB_W-1:0]  deb_ht_i,
  input  logic [DEB_W-1:0]  deb_sd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              hot_o,
  output logic              latch_o,
  output logic              ht_evt_o,
  output logic              lt_evt_o,
  output logic              sd_evt_o
);
  logic [DEB_W-1:0] ht_cnt_q, sd_cnt_q, ht_next, sd_next, ht_lim, sd_lim;
  logic             warm, crit, cold;

  function automatic logic [DEB_W-1:0] sat_inc(input logic [DEB_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_comb begin
    warm     = sample_i >= warn_i;
    crit     = sample_i >= shut_i;
    cold     = sample_i < low_i;
    ht_next  = warm ? sat_inc(ht_cnt_q) : '0;
    sd_next  = crit ? sat_inc(sd_cnt_q) : '0;
    ht_lim   = (deb_ht_i == '0) ? DEB_W'(1) : deb_ht_i;
    sd_lim   = (deb_sd_i == '0) ? DEB_W'(1) : deb_sd_i;
    ht_evt_o = fire_i & src_en_i & warm & (ht_next >= ht_lim);
    sd_evt_o = fire_i & src_en_i & crit & (sd_next >= sd_lim);
    lt_evt_o = fire_i & src_en_i & lt_en_i & cold;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      ht_cnt_q <= '0;
      sd_cnt_q <= '0;
      hot_o    <= 1'b0;
      latch_o  <= 1'b0;
    end else begin
      if (fire_i) begin
        data_o <= sample_i;
        if (src_en_i) begin
          ht_cnt_q <= ht_next;
          sd_cnt_q <= sd_next;
          hot_o    <= warm;
        end else begin
          ht_cnt_q <= '0;
          sd_cnt_q <= '0;
          hot_o    <= 1'b0;
        end
      end
      if (sd_evt_o) latch_o <= 1'b1;
    end
  end

  assert_latch_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> latch_o);

  assert_data_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (data_o == $past(sample_i)));
endmodule

// File: rtl/thermal_regs.sv
module thermal_regs
  import thermal_mon_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int PERIOD_W = 32,
  parameter int DEB_W    = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [REG_W-1:0]               rdata_o,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] data_i,
  input  logic [NUM_SRC-1:0]             ht_evt_i,
  input  logic [NUM_SRC-1:0]             lt_evt_i,
  input  logic [NUM_SRC-1:0]             sd_evt_i,
  input  logic                           round_end_i,
  output logic                           run_o,
  output logic [NUM_SRC-1:0]             src_en_o,
  output logic [NUM_SRC-1:0]             lt_en_o,
  output logic                           pol_o,
  output logic [NUM_SRC-1:0]             pin_en_o,
  output logic [NUM_SRC-1:0]             rst_en_o,
  output logic [PERIOD_W-1:0]            period_o,
  output logic [PERIOD_W-1:0]            period_ht_o,
  output logic [DEB_W-1:0]               deb_ht_o,
  output logic [DEB_W-1:0]               deb_sd_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0] warn_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0] low_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0] shut_o,
  output logic                           irq_o
);
  logic [PEND_W-1:0] ie_q, pend_q, pend_set, pend_mask;

  always_comb begin
    pend_set                   = '0;
    pend_set[P_HT +: NUM_SRC]  = ht_evt_i;
    pend_set[P_LT +: NUM_SRC]  = lt_evt_i;
    pend_set[P_SD +: NUM_SRC]  = sd_evt_i;
    pend_set[P_EOC]            = round_end_i;
    pend_mask = (we_i && addr_i == A_PEND) ? wdata_i[PEND_W-1:0] : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o       <= 1'b0;
      src_en_o    <= '0;
      lt_en_o     <= '0;
      pol_o       <= 1'b0;
      pin_en_o    <= '0;
      rst_en_o    <= '0;
      period_o    <= '0;
      period_ht_o <= '0;
      deb_ht_o    <= '0;
      deb_sd_o    <= '0;
      warn_o      <= '0;
      low_o       <= '0;
      shut_o      <= '0;
      ie_q        <= '0;
      pend_q      <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          A_CTRL: begin
            run_o    <= wdata_i[C_RUN];
            src_en_o <= wdata_i[C_SRC +: NUM_SRC];
            pol_o    <= wdata_i[C_POL];
            lt_en_o  <= wdata_i[C_LT +: NUM_SRC];
          end
          A_IE:     ie_q        <= wdata_i[PEND_W-1:0];
          A_ROUTE: begin
            pin_en_o <= wdata_i[R_PIN +: NUM_SRC];
            rst_en_o <= wdata_i[R_RST +: NUM_SRC] & ~wdata_i[R_PIN +: NUM_SRC];
          end
          A_PER:    period_o    <= wdata_i[PERIOD_W-1:0];
          A_PER_HT: period_ht_o <= wdata_i[PERIOD_W-1:0];
          A_DEB: begin
            deb_ht_o <= wdata_i[DEB_W-1:0];
            deb_sd_o <= wdata_i[DEB_W +: DEB_W];
          end
          default: ;
        endcase
        for (int n = 0; n < NUM_SRC; n++) begin
          if (addr_i == A_WARN + 4'(n)) warn_o[n] <= wdata_i[DATA_W-1:0];
          if (addr_i == A_LOW  + 4'(n)) low_o[n]  <= wdata_i[DATA_W-1:0];
          if (addr_i == A_SHUT + 4'(n)) shut_o[n] <= wdata_i[DATA_W-1:0];
        end
      end
      pend_q <= (pend_q & pend_mask) | pend_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[C_RUN]             = run_o;
        rdata_o[C_SRC +: NUM_SRC]  = src_en_o;
        rdata_o[C_POL]             = pol_o;
        rdata_o[C_LT +: NUM_SRC]   = lt_en_o;
      end
      A_IE:     rdata_o[PEND_W-1:0]   = ie_q;
      A_PEND:   rdata_o[PEND_W-1:0]   = pend_q;
      A_ROUTE: begin
        rdata_o[R_PIN +: NUM_SRC] = pin_en_o;
        rdata_o[R_RST +: NUM_SRC] = rst_en_o;
      end
      A_PER:    rdata_o[PERIOD_W-1:0] = period_o;
      A_PER_HT: rdata_o[PERIOD_W-1:0] = period_ht_o;
      A_DEB: begin
        rdata_o[DEB_W-1:0]     = deb_ht_o;
        rdata_o[DEB_W +: DEB_W] = deb_sd_o;
      end
      default: ;
    endcase
    for (int n = 0; n < NUM_SRC; n++) begin
      if (addr_i == A_DATA + 4'(n)) rdata_o[DATA_W-1:0] = data_i[n];
      if (addr_i == A_WARN + 4'(n)) rdata_o[DATA_W-1:0] = warn_o[n];
      if (addr_i == A_LOW  + 4'(n)) rdata_o[DATA_W-1:0] = low_o[n];
      if (addr_i == A_SHUT + 4'(n)) rdata_o[DATA_W-1:0] = shut_o[n];
    end
  end

  assign irq_o = |(pend_q & ie_q);

  assert_route_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ROUTE) |=> ((rst_en_o & $past(wdata_i[R_PIN +: NUM_SRC])) == '0));

  assert_eoc_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[P_EOC]) |-> $past(round_end_i));

  assert_pend_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_PEND && !wdata_i[P_EOC] && !round_end_i) |=> !pend_q[P_EOC]);
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor
  import thermal_mon_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int PERIOD_W = 32,
  parameter int DEB_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              adc_req_o,
  output logic              adc_ch_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              irq_o,
  output logic              shut_gpio_o,
  output logic              shut_rst_o
);
  localparam int CH_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                           run, pol, fire, round_end;
  logic [CH_W-1:0]                ch;
  logic [NUM_SRC-1:0]             src_en, lt_en, pin_en, rst_en;
  logic [NUM_SRC-1:0]             hot, latch, ht_evt, lt_evt, sd_evt;
  logic [PERIOD_W-1:0]            period, period_ht;
  logic [DEB_W-1:0]               deb_ht, deb_sd;
  logic [NUM_SRC-1:0][DATA_W-1:0] data, warn, low, shut;

  thermal_regs #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .DEB_W(DEB_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .data_i(data), .ht_evt_i(ht_evt), .lt_evt_i(lt_evt), .sd_evt_i(sd_evt),
    .round_end_i(round_end),
    .run_o(run), .src_en_o(src_en), .lt_en_o(lt_en), .pol_o(pol),
    .pin_en_o(pin_en), .rst_en_o(rst_en),
    .period_o(period), .period_ht_o(period_ht),
    .deb_ht_o(deb_ht), .deb_sd_o(deb_sd),
    .warn_o(warn), .low_o(low), .shut_o(shut),
    .irq_o(irq_o)
  );

  thermal_seq #(.PERIOD_W(PERIOD_W), .N_SRC(NUM_SRC), .CH_W(CH_W)) u_seq (
    .clk_i, .rst_ni,
    .run_i(run), .period_i(period), .period_ht_i(period_ht), .use_ht_i(|hot),
    .adc_done_i, .adc_req_o, .adc_ch_o(ch),
    .fire_o(fire), .round_end_o(round_end)
  );

  assign adc_ch_o = ch[0];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    thermal_chan #(.DATA_W(DATA_W), .DEB_W(DEB_W)) u_chan (
      .clk_i, .rst_ni,
      .fire_i(fire && (ch == CH_W'(n))),
      .sample_i(adc_data_i),
      .src_en_i(src_en[n]), .lt_en_i(lt_en[n]),
      .warn_i(warn[n]), .low_i(low[n]), .shut_i(shut[n]),
      .deb_ht_i(deb_ht), .deb_sd_i(deb_sd),
      .data_o(data[n]), .hot_o(hot[n]), .latch_o(latch[n]),
      .ht_evt_o(ht_evt[n]), .lt_evt_o(lt_evt[n]), .sd_evt_o(sd_evt[n])
    );
  end

  // polarity: 1 = active high
  assign shut_gpio_o = pol ? |(latch & pin_en) : ~|(latch & pin_en);
  assign shut_rst_o  = pol ? |(latch & rst_en) : ~|(latch & rst_en);
endmodule

// File: tb/thermal_monitor_tb.sv
module thermal_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        adc_req, adc_ch, irq, shut_gpio, shut_rst;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;

  always #10 clk = ~clk;

  thermal_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .adc_req_o(adc_req), .adc_ch_o(adc_ch), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .irq_o(irq), .shut_gpio_o(shut_gpio), .shut_rst_o(shut_rst)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // stimulus and model state
  logic [11:0] samp [2];
  int lat = 0;
  int gap = 0, last_gap = 0, rounds = 0;
  bit req_prev = 0;

  int m_warn = 2000, m_low = 500, m_shut = 3000;
  int m_dht = 2, m_dsd = 3, m_per = 40, m_per_ht = 20;
  bit m_en [2], m_lten [2], m_pol, m_pin [2], m_rst [2];
  int m_hc [2], m_sc [2];
  bit m_latch [2], m_hot [2];
  logic [6:0] m_pend = '0, m_ie = '0;
  int exp_gap = 0;
  bit gap_valid = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // conversion responder
  always @(negedge clk) begin
    if (!rst_n) begin
      adc_done = 1'b0; lat = 0;
    end else if (adc_done) begin
      adc_done = 1'b0;
    end else if (adc_req) begin
      if (lat == 0) begin
        adc_data = samp[adc_ch];
        adc_done = 1'b1;
        lat = $urandom % 3;
      end else lat--;
    end
  end

  // idle gap monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0; req_prev = 0;
    end else begin
      if (adc_req && !req_prev) begin last_gap = gap; gap = 0; end
      else if (!adc_req) gap++;
      if (!adc_req && req_prev) rounds++;
      req_prev = adc_req;
    end
  end

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic [31:0] ctrl_word();
    return 32'({m_lten[1], m_lten[0], m_pol, m_en[1], m_en[0], 1'b1});
  endfunction

  function automatic logic exp_out(input bit pin_side);
    bit act;
    act = pin_side ? ((m_latch[0] & m_pin[0]) | (m_latch[1] & m_pin[1]))
                   : ((m_latch[0] & m_rst[0]) | (m_latch[1] & m_rst[1]));
    return m_pol ? act : !act;
  endfunction

  task automatic model_round();
    for (int c = 0; c < 2; c++) begin
      int s = int'(samp[c]);
      if (m_en[c]) begin
        m_hc[c] = (s >= m_warn) ? ((m_hc[c] < 255) ? m_hc[c] + 1 : 255) : 0;
        m_sc[c] = (s >= m_shut) ? ((m_sc[c] < 255) ? m_sc[c] + 1 : 255) : 0;
        if (s >= m_warn && m_hc[c] >= eff(m_dht)) m_pend[c] = 1'b1;
        if (s >= m_shut && m_sc[c] >= eff(m_dsd)) begin m_pend[4+c] = 1'b1; m_latch[c] = 1; end
        if (m_lten[c] && s < m_low) m_pend[2+c] = 1'b1;
        m_hot[c] = (s >= m_warn);
      end else begin
        m_hc[c] = 0; m_sc[c] = 0; m_hot[c] = 0;
      end
    end
    m_pend[6] = 1'b1;
  endtask

  task automatic run_round(input logic [11:0] s0, input logic [11:0] s1, input bit test_keep);
    int r0;
    logic [31:0] d;
    samp[0] = s0; samp[1] = s1;
    r0 = rounds;
    do @(negedge clk); while (rounds == r0);
    model_round();
    if (gap_valid) chk("R2 idle gap", 32'(last_gap), 32'(exp_gap));
    exp_gap = (m_hot[0] || m_hot[1]) ? eff(m_per_ht) : eff(m_per);
    gap_valid = 1;
    rd(4'd8, d);  chk("R3 R9 result src0", d, 32'(s0));
    rd(4'd9, d);  chk("R3 R9 result src1", d, 32'(s1));
    rd(4'd2, d);  chk("R4 R5 R6 R9 pending", d, 32'(m_pend));
    chk("R11 irq", 32'(irq), 32'(|(m_pend & m_ie)));
    chk("R6 R7 R8 pin output", 32'(shut_gpio), 32'(exp_out(1)));
    chk("R6 R7 R8 reset output", 32'(shut_rst), 32'(exp_out(0)));
    if (test_keep) begin
      wr(4'd2, 32'h40);
      rd(4'd2, d); chk("R10 write one keeps", d, 32'h40);
    end
    wr(4'd2, 32'h0);
    m_pend = '0;
    rd(4'd2, d); chk("R10 write zero clears", d, 32'h0);
  endtask

  function automatic logic [11:0] pick();
    int r = $urandom % 10;
    if (r < 3) return 12'($urandom % m_low);
    if (r < 6) return 12'(m_low + $urandom % (m_warn - m_low));
    if (r < 9) return 12'(m_warn + $urandom % (m_shut - m_warn));
    return 12'(m_shut + $urandom % (4096 - m_shut));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7391));
    samp[0] = '0; samp[1] = '0;
    for (int c = 0; c < 2; c++) begin
      m_en[c] = 1; m_lten[c] = 1; m_hc[c] = 0; m_sc[c] = 0; m_latch[c] = 0; m_hot[c] = 0;
    end
    m_pol = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", 32'(adc_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pin output", 32'(shut_gpio), 1);
    chk("R1 reset output", 32'(shut_rst), 1);
    rst_n = 1'b1;
    rd(4'd0, d); chk("R1 control", d, 0);
    rd(4'd2, d); chk("R1 pending", d, 0);
    rd(4'd8, d); chk("R1 result", d, 0);

    // R7 routing exclusivity
    wr(4'd3, 32'h9); rd(4'd3, d); chk("R7 route readback", d, 32'h9);
    wr(4'd3, 32'hA); rd(4'd3, d); chk("R7 pin enable clears reset enable", d, 32'h2);
    wr(4'd3, 32'hD); rd(4'd3, d); chk("R7 both written", d, 32'h9);
    m_pin[0] = 1; m_pin[1] = 0; m_rst[0] = 0; m_rst[1] = 1;

    for (int c = 0; c < 2; c++) begin
      wr(4'(10 + c), 32'(m_warn));
      wr(4'(12 + c), 32'(m_low));
      wr(4'(14 + c), 32'(m_shut));
    end
    wr(4'd4, 32'(m_per));
    wr(4'd5, 32'(m_per_ht));
    wr(4'd6, 32'(m_dsd << 8 | m_dht));
    m_ie = 7'h3F; wr(4'd1, 32'h3F);
    wr(4'd0, ctrl_word());

    // directed debounce boundaries (R4, R6)
    run_round(12'd2000, 12'd1999, 0);
    gap_valid = 0;
    run_round(12'd2000, 12'd10,   1);
    run_round(12'd1999, 12'd3000, 0);
    run_round(12'd2500, 12'd3000, 0);
    run_round(12'd2500, 12'd2999, 0);
    run_round(12'd100,  12'd3000, 0);
    run_round(12'd100,  12'd3000, 0);
    run_round(12'd600,  12'd3000, 0);
    run_round(12'd600,  12'd3001, 0);

    // random mix
    for (int i = 0; i < 30; i++) run_round(pick(), pick(), (i % 7) == 0);

    // R8 polarity flip
    m_pol = 1; wr(4'd0, ctrl_word());
    @(negedge clk);
    chk("R8 pin output high-active", 32'(shut_gpio), 32'(exp_out(1)));
    chk("R8 reset output high-active", 32'(shut_rst), 32'(exp_out(0)));

    // R9 disabled source fed hot codes
    m_en[1] = 0; wr(4'd0, ctrl_word());
    for (int i = 0; i < 4; i++) run_round(12'd700, 12'd3500, 0);
    m_en[1] = 1; wr(4'd0, ctrl_word());
    run_round(12'd700, 12'd2100, 0);
    run_round(12'd700, 12'd2100, 0);

    // R4 debounce of zero acts as one, low compare off for src0 (R5)
    m_dht = 0; m_dsd = 1; wr(4'd6, 32'h100);
    m_lten[0] = 0; wr(4'd0, ctrl_word());
    m_ie = 7'h40; wr(4'd1, 32'h40);
    run_round(12'd20, 12'd2000, 0);
    run_round(12'd2000, 12'd20, 0);
    for (int i = 0; i < 10; i++) run_round(pick(), pick(), 0);

    // R2 zero period
    samp[0] = 12'd600; samp[1] = 12'd600;
    m_per = 0; wr(4'd4, 32'h0);
    m_per_ht = 0; wr(4'd5, 32'h0);
    repeat (40) @(negedge clk);
    chk("R2 zero period gap", 32'(last_gap), 32'd1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule